// File: doc/BRIEF.md
# Audio Tone and Volume Control Target (Write-Only I2C)

This block is the digital control section of a stereo tone and volume controller. It listens on a two-wire I2C bus as a write-only target. SCL and SDA come in from open-drain pins and are oversampled by a fast system clock. The block finds START and STOP conditions and matches a fixed device address. It then takes two bytes. The first byte is acknowledged and thrown away. The second byte carries a register selector in its top three bits and a value in the bits below.

Seven small settings are kept:
- input gain
- bass
- treble
- left volume
- right volume
- input source selection
- an operating-mode byte

The block merges these settings with three board pins: an active-low shutdown pin, a 3D-effect pin and a headphone-detect pin. From them it produces the control outputs for the analog side: per-channel effective mute, a signed decibel level per channel, 3D enable, shutdown, and the speaker and headphone path enables.

Top module: `audio_ctl_i2c_target`

## Requirements
- R1: After reset the settings read gain code 6, bass 6, treble 6, both volume codes 16 (-12 dB), input select 0 and all mode bits 0. With the pins inactive, the speaker path is enabled and nothing is muted.
- R2: The target acknowledges only the address byte 0x80 (R/W bit 0). It pulls SDA low during the ninth clock. Any other address byte, including 0x81, gets no acknowledge and writes nothing.
- R3: After a matched address, the next two bytes are each acknowledged in their ninth clock. A further byte in the same transfer is not acknowledged and not stored.
- R4: The second byte after the address is the command. Bits 7:5 select the target:
  - 000: gain, stored from bits 2:0
  - 001: bass, stored from bits 3:0
  - 010: treble, stored from bits 3:0
  - 011: left volume, stored from bits 4:0
  - 100: right volume, stored from bits 4:0
  - 101: input select, stored from bits 1:0
  - 111: mode, where bit 4 is mute-all, bit 2 is 3D, bit 1 is speaker disable and bit 0 is soft shutdown
  - 110: changes nothing
- R5: A STOP or a repeated START before the command byte completes stores nothing. A complete transfer after a repeated START is accepted normally.
- R6: The channel level output is signed dB. Code c from 1 to 27 gives 2c-44 dB. Codes 28 to 31 give +12 dB. A muted channel reads 0.
- R7: Mute-all mutes both channels but keeps the stored volume codes. Clearing it restores the previous levels. A volume code of 0 mutes only its own channel.
- R8: 3D enable is the OR of the 3D mode bit and the 3D pin.
- R9: Shutdown is active when the soft-shutdown bit is 1 or the shutdown pin is low. Stored settings are kept during shutdown.
- R10: The speaker path is enabled only when the block is not shut down, the speaker-disable bit is 0 and headphone detect is low. The headphone path is enabled when the block is not shut down and headphone detect is high.
- R11: Asserting the asynchronous reset at any time returns all settings to the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least ten times the bus rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock from pin |
| sda_i | input | 1 | Bus data from pin (resolved line) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sd_pin_ni | input | 1 | Hardware shutdown pin, active low |
| td_pin_i | input | 1 | 3D enable pin |
| hp_det_i | input | 1 | Headphone detect |
| in_gain_o | output | 3 | Input gain code |
| bass_o | output | 4 | Bass code |
| treble_o | output | 4 | Treble code |
| vol_l_o | output | 5 | Stored left volume code |
| vol_r_o | output | 5 | Stored right volume code |
| in_sel_o | output | 2 | Input source select |
| gain_l_db_o | output | 7 | Left level in dB, signed |
| gain_r_db_o | output | 7 | Right level in dB, signed |
| mute_l_o | output | 1 | Left effective mute |
| mute_r_o | output | 1 | Right effective mute |
| en3d_o | output | 1 | 3D effect enable |
| shutdown_o | output | 1 | Effective shutdown |
| spk_en_o | output | 1 | Speaker path enable |
| hp_en_o | output | 1 | Headphone path enable |

## Verification
The bench targets the transfers where a slip in the bit engine changes state without warning:
- The 0x81 address and a stray third byte: a loose matcher would acknowledge these and corrupt settings.
- A STOP after four data bits and a repeated START after three: a design that commits partial shift contents would store garbage.

Volume codes 1, 22, 27, 28 and 31 pin down the ends and the +12 dB ceiling of the level mapping. An off-by-one would show up as a 2 dB error.

Mute-all is set and then cleared with distinct left and right codes. A design that zeroes the stored volumes would not restore them.

The pin tests cover the OR of each pin with its bit and the headphone override. They also cover shutdown with settings retained.

// File: rtl/actl_pkg.sv
package actl_pkg;
  typedef enum logic [2:0] {
    SEL_GAIN = 3'd0,
    SEL_BASS = 3'd1,
    SEL_TREB = 3'd2,
    SEL_VOLL = 3'd3,
    SEL_VOLR = 3'd4,
    SEL_MUX  = 3'd5,
    SEL_RSVD = 3'd6,
    SEL_MODE = 3'd7
  } sel_e;

  typedef struct packed {
    logic mute_all;
    logic en3d;
    logic spk_dis;
    logic sw_sd;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_REG, ST_ACK_R, ST_DATA, ST_ACK_D
  } rx_st_e;
endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q[g] <= RST_VAL;
      else if (g == 0) q[g] <= d_i;
      else             q[g] <= q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/actl_i2c_rx.sv
module actl_i2c_rx import actl_pkg::*; #(
  parameter logic [7:0] DEV_ADDR = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  output logic       sda_oe_o,
  output logic       wr_o,
  output logic [7:0] wr_data_o
);
  localparam logic [3:0] BITS = 4'd8;

  logic   scl_q, sda_q;
  logic   start, stop, scl_rise, scl_fall;
  rx_st_e st;
  logic [3:0] cnt;
  logic [7:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign start    = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop     = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign scl_rise = ~scl_q & scl_s_i;
  assign scl_fall = scl_q & ~scl_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      sda_oe_o  <= 1'b0;
      wr_o      <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (start) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_REG, ST_DATA: begin
            if (scl_rise && cnt != BITS) begin
              sh  <= {sh[6:0], sda_s_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS) begin
              unique case (st)
                ST_ADDR: begin
                  if (sh == DEV_ADDR) begin
                    sda_oe_o <= 1'b1;
                    st       <= ST_ACK_A;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                ST_REG: begin
                  sda_oe_o <= 1'b1;
                  st       <= ST_ACK_R;
                end
                default: begin
                  sda_oe_o  <= 1'b1;
                  wr_o      <= 1'b1;
                  wr_data_o <= sh;
                  st        <= ST_ACK_D;
                end
              endcase
            end
          end
          ST_ACK_A, ST_ACK_R, ST_ACK_D: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              st       <= (st == ST_ACK_A) ? ST_REG :
                          (st == ST_ACK_R) ? ST_DATA : ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/actl_regs.sv
module actl_regs import actl_pkg::*; #(
  parameter int unsigned GAIN_W = 3,
  parameter int unsigned TONE_W = 4,
  parameter int unsigned VOL_W  = 5,
  parameter int unsigned MUX_W  = 2,
  parameter logic [GAIN_W-1:0] GAIN_RST = 3'd6,
  parameter logic [TONE_W-1:0] TONE_RST = 4'd6,
  parameter logic [VOL_W-1:0]  VOL_RST  = 5'd16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wr_data_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [TONE_W-1:0] bass_o,
  output logic [TONE_W-1:0] treble_o,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [VOL_W-1:0]  vol_r_o,
  output logic [MUX_W-1:0]  sel_o,
  output mode_t             mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o   <= GAIN_RST;
      bass_o   <= TONE_RST;
      treble_o <= TONE_RST;
      vol_l_o  <= VOL_RST;
      vol_r_o  <= VOL_RST;
      sel_o    <= '0;
      mode_o   <= '0;
    end else if (wr_i) begin
      unique case (sel_e'(wr_data_i[7:5]))
        SEL_GAIN: gain_o   <= wr_data_i[GAIN_W-1:0];
        SEL_BASS: bass_o   <= wr_data_i[TONE_W-1:0];
        SEL_TREB: treble_o <= wr_data_i[TONE_W-1:0];
        SEL_VOLL: vol_l_o  <= wr_data_i[VOL_W-1:0];
        SEL_VOLR: vol_r_o  <= wr_data_i[VOL_W-1:0];
        SEL_MUX:  sel_o    <= wr_data_i[MUX_W-1:0];
        SEL_MODE: mode_o   <= '{mute_all: wr_data_i[4], en3d: wr_data_i[2],
                                spk_dis: wr_data_i[1], sw_sd: wr_data_i[0]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/actl_chan.sv
module actl_chan #(
  parameter int unsigned VOL_W    = 5,
  parameter int unsigned DB_W     = 7,
  parameter int          FLOOR_DB = -44,
  parameter int          STEP_DB  = 2,
  parameter int          CAP_CODE = 28
) (
  input  logic [VOL_W-1:0]       code_i,
  input  logic                   mute_all_i,
  output logic                   mute_o,
  output logic signed [DB_W-1:0] db_o
);
  int cl, lvl;

  always_comb begin
    cl = int'(code_i);
    if (cl > CAP_CODE) cl = CAP_CODE;
    lvl    = FLOOR_DB + STEP_DB * cl;
    mute_o = mute_all_i | (code_i == '0);
    db_o   = mute_o ? '0 : $signed(DB_W'(lvl));
  end
endmodule

// File: rtl/audio_ctl_i2c_target.sv
module audio_ctl_i2c_target import actl_pkg::*; #(
  parameter logic [7:0]  DEV_ADDR    = 8'h80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              sd_pin_ni,
  input  logic              td_pin_i,
  input  logic              hp_det_i,
  output logic [2:0]        in_gain_o,
  output logic [3:0]        bass_o,
  output logic [3:0]        treble_o,
  output logic [4:0]        vol_l_o,
  output logic [4:0]        vol_r_o,
  output logic [1:0]        in_sel_o,
  output logic signed [6:0] gain_l_db_o,
  output logic signed [6:0] gain_r_db_o,
  output logic              mute_l_o,
  output logic              mute_r_o,
  output logic              en3d_o,
  output logic              shutdown_o,
  output logic              spk_en_o,
  output logic              hp_en_o
);
  localparam int unsigned VOL_W = 5;
  localparam int unsigned DB_W  = 7;
  localparam int unsigned NCH   = 2;

  logic       scl_s, sda_s;
  logic       wr;
  logic [7:0] wr_data;
  mode_t      mode;

  actl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  actl_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .sda_oe_o, .wr_o(wr), .wr_data_o(wr_data)
  );

  actl_regs #(.VOL_W(VOL_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .wr_data_i(wr_data),
    .gain_o(in_gain_o), .bass_o, .treble_o,
    .vol_l_o, .vol_r_o, .sel_o(in_sel_o), .mode_o(mode)
  );

  logic [VOL_W-1:0]       codes [NCH];
  logic                   mutes [NCH];
  logic signed [DB_W-1:0] dbs   [NCH];

  assign codes[0] = vol_l_o;
  assign codes[1] = vol_r_o;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    actl_chan #(.VOL_W(VOL_W), .DB_W(DB_W)) u_chan (
      .code_i(codes[ch]), .mute_all_i(mode.mute_all),
      .mute_o(mutes[ch]), .db_o(dbs[ch])
    );
  end

  assign mute_l_o    = mutes[0];
  assign mute_r_o    = mutes[1];
  assign gain_l_db_o = dbs[0];
  assign gain_r_db_o = dbs[1];

  assign shutdown_o = mode.sw_sd | ~sd_pin_ni;
  assign en3d_o     = mode.en3d | td_pin_i;
  assign spk_en_o   = ~shutdown_o & ~mode.spk_dis & ~hp_det_i;
  assign hp_en_o    = ~shutdown_o & hp_det_i;
endmodule

// File: rtl/actl_checker.sv
module actl_checker (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_oe_o,
  input logic              sd_pin_ni,
  input logic              td_pin_i,
  input logic              hp_det_i,
  input logic [4:0]        vol_l_o,
  input logic [4:0]        vol_r_o,
  input logic signed [6:0] gain_l_db_o,
  input logic signed [6:0] gain_r_db_o,
  input logic              mute_l_o,
  input logic              mute_r_o,
  input logic              en3d_o,
  input logic              shutdown_o,
  input logic              spk_en_o,
  input logic              hp_en_o
);
  p_ack_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  p_vol0_mute_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_l_o == 5'd0) |-> (mute_l_o && gain_l_db_o == 7'sd0));

  p_vol0_mute_r_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_r_o == 5'd0) |-> (mute_r_o && gain_r_db_o == 7'sd0));

  p_db_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_l_o[4:2] == 3'b111 && !mute_l_o) |-> (gain_l_db_o == 7'sd12));

  p_db_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_r_db_o <= 7'sd12 && gain_r_db_o >= -7'sd42));

  p_3d_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    td_pin_i |-> en3d_o);

  p_sd_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_pin_ni |-> (shutdown_o && !spk_en_o && !hp_en_o));

  p_hp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_det_i |-> !spk_en_o);

  p_path_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spk_en_o && hp_en_o));
endmodule

bind audio_ctl_i2c_target actl_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .sd_pin_ni(sd_pin_ni), .td_pin_i(td_pin_i), .hp_det_i(hp_det_i),
  .vol_l_o(vol_l_o), .vol_r_o(vol_r_o),
  .gain_l_db_o(gain_l_db_o), .gain_r_db_o(gain_r_db_o),
  .mute_l_o(mute_l_o), .mute_r_o(mute_r_o), .en3d_o(en3d_o),
  .shutdown_o(shutdown_o), .spk_en_o(spk_en_o), .hp_en_o(hp_en_o)
);

// File: tb/audio_ctl_i2c_target_tb_top.sv
module audio_ctl_i2c_target_tb_top;
  localparam int Q = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic sd_n = 1'b1, td = 1'b0, hp = 1'b0;
  logic sda_oe, sda_bus;
  logic [2:0] gain;
  logic [3:0] bass, treb;
  logic [4:0] vl, vr;
  logic [1:0] isel;
  logic signed [6:0] dbl, dbr;
  logic ml, mr, e3d, sd, spk, hpe;
  int n_run = 0, n_fail = 0;
  logic [2:0] acks;

  always #10 clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  audio_ctl_i2c_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .sd_pin_ni(sd_n), .td_pin_i(td), .hp_det_i(hp),
    .in_gain_o(gain), .bass_o(bass), .treble_o(treb), .vol_l_o(vl), .vol_r_o(vr),
    .in_sel_o(isel), .gain_l_db_o(dbl), .gain_r_db_o(dbr), .mute_l_o(ml),
    .mute_r_o(mr), .en3d_o(e3d), .shutdown_o(sd), .spk_en_o(spk), .hp_en_o(hpe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_drv = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_bus;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] r, input logic [7:0] d,
                      output logic [2:0] ak);
    bus_start();
    send_byte(a, ak[2]); send_byte(r, ak[1]); send_byte(d, ak[0]);
    bus_stop();
  endtask

  task automatic wr(input logic [7:0] d);
    logic [2:0] ak;
    xfer(8'h80, 8'h00, d, ak);
  endtask

  task automatic t_reset();
    chk("R1 gain", gain, 6); chk("R1 bass", bass, 6); chk("R1 treble", treb, 6);
    chk("R1 vol_l", vl, 16); chk("R1 vol_r", vr, 16); chk("R1 sel", isel, 0);
    chk("R1 db_l", dbl, -12); chk("R1 mute", {ml, mr}, 0);
    chk("R1 spk", spk, 1); chk("R1 3d", e3d, 0); chk("R1 sd", sd, 0);
  endtask

  task automatic t_addr();
    logic a0, a1;
    bus_start(); send_byte(8'h81, a0); send_byte(8'h2C, a1); bus_stop();
    chk("R2 ack 0x81", a0, 0); chk("R2 no write 0x81", bass, 6);
    xfer(8'h82, 8'h00, 8'h2C, acks);
    chk("R2 ack 0x82", acks, 0); chk("R2 no write 0x82", bass, 6);
  endtask

  task automatic t_fields();
    logic a3;
    bus_start(); send_byte(8'h80, acks[2]); send_byte(8'h55, acks[1]);
    send_byte(8'h03, acks[0]); send_byte(8'h2C, a3); bus_stop();
    chk("R3 acks", acks, 7); chk("R3 extra byte nak", a3, 0);
    chk("R4 gain", gain, 3); chk("R3 extra byte ignored", bass, 6);
    wr(8'h29); chk("R4 bass", bass, 9);
    wr(8'h4C); chk("R4 treble", treb, 12);
    wr(8'h75); chk("R4 vol_l", vl, 21);
    wr(8'h87); chk("R4 vol_r", vr, 7);
    wr(8'hA3); chk("R4 sel", isel, 3);
    wr(8'hC0);
    chk("R4 rsvd gain", gain, 3); chk("R4 rsvd bass", bass, 9);
    chk("R4 rsvd vol", vl, 21); chk("R4 rsvd sel", isel, 3);
  endtask

  task automatic t_abort();
    logic a;
    bus_start(); send_byte(8'h80, a); send_byte(8'h00, a); send_bits(8'h25, 4); bus_stop();
    chk("R5 stop abort", bass, 9);
    bus_start(); send_byte(8'h80, a); send_byte(8'h00, a); send_bits(8'h22, 3);
    bus_start(); send_byte(8'h80, acks[2]); send_byte(8'h00, acks[1]);
    send_byte(8'h2A, acks[0]); bus_stop();
    chk("R5 restart acks", acks, 7); chk("R5 restart write", bass, 10);
  endtask

  task automatic t_vol();
    wr(8'h61); chk("R6 code1", dbl, -42);
    wr(8'h76); chk("R6 code22", dbl, 0);
    wr(8'h7B); chk("R6 code27", dbl, 10);
    wr(8'h7C); chk("R6 code28", dbl, 12);
    wr(8'h7F); chk("R6 code31", dbl, 12);
    wr(8'h80); chk("R6 code0 db", dbl, 12); chk("R6 code0 r db", dbr, 0);
  endtask

  task automatic t_mute();
    wr(8'h85); chk("R7 r only mute", {ml, mr}, 2'b00);
    wr(8'h60); chk("R7 l code0", {ml, mr}, 2'b10);
    wr(8'h78);
    wr(8'hF0);
    chk("R7 mute all", {ml, mr}, 2'b11); chk("R7 keep l", vl, 24); chk("R7 keep r", vr, 5);
    chk("R7 db muted", dbl, 0);
    wr(8'hE0);
    chk("R7 restore l", dbl, 4); chk("R7 restore r", dbr, -34); chk("R7 unmute", {ml, mr}, 0);
  endtask

  task automatic t_pins();
    td = 1'b1; @(negedge clk); chk("R8 pin 3d", e3d, 1);
    td = 1'b0; wr(8'hE4); chk("R8 bit 3d", e3d, 1);
    wr(8'hE0); chk("R8 both off", e3d, 0);
    sd_n = 1'b0; @(negedge clk); chk("R9 pin sd", sd, 1); chk("R9 pin sd spk", spk, 0);
    sd_n = 1'b1; wr(8'hE1); chk("R9 bit sd", sd, 1);
    wr(8'h2D); chk("R9 retain/write in sd", bass, 13);
    wr(8'hE0); chk("R9 sd off", sd, 0); chk("R9 retained vol", vl, 24);
    hp = 1'b1; @(negedge clk); chk("R10 hp spk", spk, 0); chk("R10 hp en", hpe, 1);
    hp = 1'b0; wr(8'hE2); @(negedge clk);
    chk("R10 spk dis", spk, 0); chk("R10 hp off", hpe, 0);
    wr(8'hE0); chk("R10 spk back", spk, 1);
  endtask

  task automatic t_async_reset();
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b0; #2;
    chk("R11 bass", bass, 6); chk("R11 vol_l", vl, 16); chk("R11 gain", gain, 6);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_fields();
    t_abort();
    t_vol();
    t_mute();
    t_pins();
    t_async_reset();
    finish_run();
  end
endmodule